// File: doc/BRIEF.md
# Beat Repeater Stage

This is a ready/valid pipeline stage that turns one upstream transfer into several downstream transfers. An upstream producer offers a data word together with a repeat count. The stage captures both, then presents the word on its output once for every repetition. Each repetition is a separate output handshake.

The upstream handshake is held open until the last repetition has been taken downstream. The producer therefore sees the whole multi-beat job as one transfer, and the moment its handshake completes marks the end of the job. A count of zero is acknowledged at once and produces no output.

A typical use is to repeat one command word for a block transfer of a given length. A later stage counts the beats and generates addresses from them.

Top module: `beat_repeater`

## Requirements
- R1: An operation with count N > 0 produces exactly N accepted output beats (cycles with out_valid and out_ready both high). Every beat carries the word that was captured for that operation.
- R2: When in_valid is high in the idle state with in_count equal to 0, in_ready is high in that same cycle. No output beat follows, and out_valid stays low in the next cycle.
- R3: For N > 0, in_ready stays low while beats remain. It goes high for one cycle, the cycle after the final beat is accepted, and out_valid is low in that cycle.
- R4: The word and the count are captured in the first cycle in_valid is seen in the idle state. out_data stays constant over all beats of an operation, even if in_data changes while the operation runs.
- R5: While beats remain and out_ready is low, out_valid stays high and out_data does not change. The remaining count falls only on accepted beats.
- R6: clr is synchronous. In the cycle after clr is sampled high, out_valid is low. With in_valid low, in_ready is also low in that cycle. Any partly finished operation is discarded.
- R7: An operation presented in the cycle after the previous one completed is captured in that cycle, and its first beat is valid in the following cycle.
- R8: MAX_REPEAT defaults to 255. in_count is $clog2(MAX_REPEAT)+1 bits wide (9 by default), so a count of 255 is accepted and yields 255 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| in_valid | input | 1 | Upstream offers an operation |
| in_ready | output | 1 | Operation complete, upstream handshake done |
| in_data | input | WIDTH | Word to repeat |
| in_count | input | $clog2(MAX_REPEAT)+1 | Number of repetitions |
| out_valid | output | 1 | A repetition is offered downstream |
| out_ready | input | 1 | Downstream accepts the repetition |
| out_data | output | WIDTH | Captured word |

## Verification
The assertions assume a well-behaved producer. Once it raises in_valid it keeps it high, and keeps in_count unchanged, until in_ready completes the handshake. This assumption lets the beat total be compared against the count at the moment of completion. The stimulus keeps to this rule by holding valid and count from a single driver task until it sees in_ready. The one exception is in_data, which is deliberately disturbed in the middle of an operation to test R4. The only break in the protocol is a clear issued mid-operation, and the bench drops valid during that clear.

// File: rtl/beat_rep_pkg.sv
package beat_rep_pkg;

    // Control states of the repeater.
    typedef enum logic [1:0] {
        REP_IDLE = 2'd0,
        REP_RUN  = 2'd1,
        REP_DONE = 2'd2
    } rep_state_e;

endpackage

// File: rtl/beat_rep_fsm.sv
module beat_rep_fsm
    import beat_rep_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       start_nz,   // idle, valid operation with non-zero count
    input  logic       last_fire,  // final beat accepted this cycle
    output rep_state_e state
);

    typedef struct packed {
        rep_state_e state;
    } fsm_t;

    fsm_t fsm_q;
    fsm_t fsm_d;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.state)
            REP_IDLE: if (start_nz)  fsm_d.state = REP_RUN;
            REP_RUN:  if (last_fire) fsm_d.state = REP_DONE;
            REP_DONE: fsm_d.state = REP_IDLE;
            default:  fsm_d.state = REP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) fsm_q <= '{state: REP_IDLE};
        else     fsm_q <= fsm_d;
    end

    assign state = fsm_q.state;

endmodule

// File: rtl/beat_rep_store.sv
module beat_rep_store #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic [CNT_W-1:0] load_count,
    input  logic             take,
    output logic [WIDTH-1:0] word,
    output logic             last
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic [CNT_W-1:0] left;
    } store_t;

    store_t st_q;
    store_t st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.word = load_word;
            st_d.left = load_count;
        end else if (take) begin
            st_d.left = st_q.left - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word = st_q.word;
    assign last = (st_q.left == CNT_ONE);

endmodule

// File: rtl/beat_repeater.sv
module beat_repeater
    import beat_rep_pkg::*;
#(
    parameter  int WIDTH      = 32,
    parameter  int MAX_REPEAT = 255,
    localparam int CNT_W      = $clog2(MAX_REPEAT) + 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    input  logic [CNT_W-1:0] in_count,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    rep_state_e       state;
    logic             zero_req;
    logic             start_nz;
    logic             out_fire;
    logic             last;
    logic             last_fire;
    logic [WIDTH-1:0] held_word;

    assign zero_req  = (in_count == '0);
    assign start_nz  = (state == REP_IDLE) && in_valid && !zero_req;
    assign out_valid = (state == REP_RUN);
    assign out_fire  = out_valid && out_ready;
    assign last_fire = out_fire && last;
    assign in_ready  = (state == REP_DONE) ||
                       ((state == REP_IDLE) && in_valid && zero_req);
    assign out_data  = held_word;

    beat_rep_fsm u_fsm (
        .clk       (clk),
        .clr       (clr),
        .start_nz  (start_nz),
        .last_fire (last_fire),
        .state     (state)
    );

    beat_rep_store #(
        .WIDTH (WIDTH),
        .CNT_W (CNT_W)
    ) u_store (
        .clk        (clk),
        .clr        (clr),
        .load       (start_nz),
        .load_word  (in_data),
        .load_count (in_count),
        .take       (out_fire),
        .word       (held_word),
        .last       (last)
    );

endmodule

// File: rtl/beat_repeater_chk.sv
module beat_repeater_chk #(
    parameter  int WIDTH      = 32,
    parameter  int MAX_REPEAT = 255,
    localparam int CNT_W      = $clog2(MAX_REPEAT) + 1
) (
    input logic             clk,
    input logic             clr,
    input logic             in_valid,
    input logic             in_ready,
    input logic [CNT_W-1:0] in_count,
    input logic             out_valid,
    input logic             out_ready,
    input logic [WIDTH-1:0] out_data
);

    // Beats accepted since the last completed input handshake.
    logic [CNT_W-1:0] beats_q;

    always_ff @(posedge clk) begin
        if (clr || (in_valid && in_ready)) beats_q <= '0;
        else if (out_valid && out_ready)   beats_q <= beats_q + CNT_W'(1);
    end

    assert_beat_total_R1: assert property (@(posedge clk) disable iff (clr)
        (in_valid && in_ready) |-> (beats_q == in_count));

    assert_zero_silent_R2: assert property (@(posedge clk) disable iff (clr)
        (in_valid && in_ready && in_count == '0) |=> !out_valid);

    assert_no_early_ready_R3: assert property (@(posedge clk) disable iff (clr)
        out_valid |-> !in_ready);

    assert_word_constant_R4: assert property (@(posedge clk) disable iff (clr)
        (out_valid && $past(out_valid)) |-> $stable(out_data));

    assert_valid_held_R5: assert property (@(posedge clk) disable iff (clr)
        (out_valid && !out_ready) |=> out_valid);

    assert_data_held_R5: assert property (@(posedge clk) disable iff (clr)
        (out_valid && !out_ready) |=> $stable(out_data));

    assert_clear_idle_R6: assert property (@(posedge clk)
        clr |=> !out_valid);

endmodule

bind beat_repeater beat_repeater_chk #(
    .WIDTH      (WIDTH),
    .MAX_REPEAT (MAX_REPEAT)
) u_chk (
    .clk       (clk),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_count  (in_count),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/beat_repeater_tb.sv
module beat_repeater_tb;

    localparam int WIDTH      = 32;
    localparam int MAX_REPEAT = 255;
    localparam int CNT_W      = $clog2(MAX_REPEAT) + 1;

    logic             clk = 1'b0;
    logic             clr = 1'b1;
    logic             in_valid = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic [CNT_W-1:0] in_count = '0;
    logic             out_ready = 1'b0;
    wire              in_ready;
    wire              out_valid;
    wire  [WIDTH-1:0] out_data;

    int checks = 0;
    int fails = 0;
    int beats_seen = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [WIDTH-1:0] exp_q[$];
    logic prev_stall = 1'b0;
    logic [WIDTH-1:0] prev_data = '0;
    bit done = 0;

    always #4 clk = ~clk;

    beat_repeater #(.WIDTH(WIDTH), .MAX_REPEAT(MAX_REPEAT)) u_dut (
        .clk(clk), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_count(in_count), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk_eq(input string tag, input logic [WIDTH-1:0] act,
                          input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Downstream ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0];
            default: out_ready = 1'b0;
        endcase
    end

    // Monitor: pops the scoreboard on each accepted beat.
    always @(negedge clk) begin
        if (clr) begin
            prev_stall = 1'b0;
        end else begin
            if (prev_stall) begin
                chk_eq("R5 valid held while stalled", out_valid, 1);
                chk_eq("R5 data held while stalled", out_data, prev_data);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk_eq("R1 unexpected beat", out_data, '1);
                end else begin
                    chk_eq("R1/R4 beat data", out_data, exp_q.pop_front());
                end
                beats_seen++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    // Driver: one operation, held until in_ready completes it.
    task automatic send_op(input logic [WIDTH-1:0] w, input int n, input bit wiggle);
        int start_seen;
        @(negedge clk);
        for (int i = 0; i < n; i++) exp_q.push_back(w);
        start_seen = beats_seen;
        in_valid = 1'b1;
        in_data  = w;
        in_count = CNT_W'(n);
        #1;
        if (n == 0) begin
            chk_eq("R2 zero count acknowledged same cycle", in_ready, 1);
        end else begin
            chk_eq("R3 no ready at capture", in_ready, 0);
            @(negedge clk);
            #1;
            chk_eq("R7 first beat valid next cycle", out_valid, 1);
            if (wiggle) in_data = ~w;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            chk_eq("R3 all beats taken before ready", exp_q.size(), 0);
            chk_eq("R3 out_valid low with ready", out_valid, 0);
        end
        chk_eq("R1 beat total", beats_seen - start_seen, n);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_count = '0;
        in_data  = '0;
        if (n == 0) chk_eq("R2 no output after zero count", out_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_eq("R6 reset out_valid", out_valid, 0);
        chk_eq("R6 reset in_ready", in_ready, 0);
        clr = 1'b0;

        rdy_mode = 0;
        send_op(32'hA000_0001, 1, 0);
        send_op(32'hB000_0004, 4, 0);
        send_op(32'hDEAD_0000, 0, 0);
        send_op(32'hC000_0003, 3, 0);

        rdy_mode = 1;
        send_op(32'hD000_0007, 7, 1);   // R4: input bus disturbed mid-run
        send_op(32'hE000_0002, 2, 0);
        send_op(32'h1234_0000, 0, 0);

        rdy_mode = 2;                   // R5 stall window
        fork
            send_op(32'h5A5A_0006, 6, 0);
            begin
                repeat (12) @(negedge clk);
                rdy_mode = 1;
            end
        join

        // R6: clear in the middle of an operation
        rdy_mode = 0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) exp_q.push_back(32'h6666_0010);
        in_valid = 1'b1;
        in_data  = 32'h6666_0010;
        in_count = CNT_W'(10);
        repeat (4) @(negedge clk);
        #1;
        clr = 1'b1;
        in_valid = 1'b0;
        in_count = '0;
        @(negedge clk);
        #1;
        chk_eq("R6 out_valid after clear", out_valid, 0);
        chk_eq("R6 in_ready after clear", in_ready, 0);
        clr = 1'b0;
        exp_q.delete();
        send_op(32'hF000_0005, 5, 0);

        rdy_mode = 1;
        send_op(32'h7777_00FF, 255, 0); // R8 largest count
        send_op(32'h8888_0001, 1, 0);

        repeat (3) @(negedge clk);
        chk_eq("R1 no stray beats left", exp_q.size(), 0);
        report();
    end

endmodule